// File: doc/BRIEF.md
# Multi-mode 16-bit timer/counter

This block is a 16-bit up/down timer/counter with a 16-bit reload/capture register pair. It has four modes. In capture mode a falling edge on the trigger pin copies the running count into the pair. In auto-reload mode the counter is reloaded on wrap or on a trigger edge. In up/down mode the trigger pin sets the direction and the external flag acts as a 17th count bit. In rate-generator mode the counter runs at state-time rate and produces a baud tick and/or a 50% duty square wave.

The clock sources are enable strobes from the surrounding system: one per machine cycle and one per state time. In counter mode the source is the external count pin, sampled on machine-cycle strobes. Software reaches the control, mode, counter and reload bytes through a small address/data bus. It reads back two sticky flags: one for wrap/underflow and one for external events.

Top module: `tc16`

## Requirements
- R1: Register map (address: content): 0 control {bit7 ext flag, bit6 wrap flag, bit5 capture select, bit4 transmit-rate select, bit3 receive-rate select, bit2 external enable, bit1 count-pin select, bit0 run}; 1 mode {bit1 clock-out enable, bit0 down-count enable}; 2/3 counter low/high; 4/5 reload low/high. After reset every register reads 0, and both flags, `clk_out` and `baud_tick` are 0.
- R2: In timer operation (count-pin select 0, no rate mode) the running counter advances by one on each cycle with `mc_tick` high. `st_tick` alone does nothing.
- R3: With count-pin select 1, `cnt_pin` is sampled on `mc_tick` cycles. The counter advances on an `mc_tick` cycle where the previous sample was 1 and the pin is now 0.
- R4: Capture mode (capture select 1) wraps FFFFh to 0000h and sets the wrap flag. With external enable 1, a `trg_pin` falling edge (seen on an `mc_tick`) copies the pre-step count into the reload pair and sets the ext flag.
- R5: Auto-reload up mode (capture select 0, down-count 0) loads the reload pair instead of wrapping past FFFFh and sets the wrap flag. With external enable 1, a trigger falling edge also loads the reload pair, taking priority over counting, and sets the ext flag.
- R6: Up/down mode (down-count 1): `trg_pin` high counts up, reloading from the pair past FFFFh. `trg_pin` low counts down; a step taken while the counter equals the reload pair loads FFFFh. Both events set the wrap flag and toggle the ext flag.
- R7: In up/down mode trigger falling edges neither reload the counter nor change the ext flag.
- R8: Either rate select bit enters rate mode. The counter then steps on `st_tick` only and reloads from the pair past FFFFh without setting the wrap flag. `baud_tick` pulses for one cycle on every 16th such wrap.
- R9: In rate mode a trigger falling edge with external enable 1 sets the ext flag and does not reload the counter.
- R10: Clock-out mode (clock-out enable 1, count-pin select 0) steps on `st_tick`, reloads on wrap without setting the wrap flag, and toggles `clk_out` on each wrap.
- R11: Writing 0 to a flag bit of the control register clears it, and writing 1 leaves it unchanged. A hardware set in the same cycle as a clearing write wins.
- R12: With run 0 the counter holds while the count-pin sampler keeps tracking the pin, so setting run again counts no stale edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_tick | input | 1 | Machine-cycle strobe |
| st_tick | input | 1 | State-time strobe |
| cnt_pin | input | 1 | External count input |
| trg_pin | input | 1 | Trigger / direction input |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| ovf_flag | output | 1 | Wrap/underflow flag |
| ext_flag | output | 1 | External event flag |
| baud_tick | output | 1 | One-cycle pulse per 16 rate-mode wraps |
| clk_out | output | 1 | Square-wave clock output |

## Verification
Each mode gets directed corner cases placed right at FFFFh, or at the reload value when counting down. These cases separate wrap-to-zero, reload, load of FFFFh and flag suppression. Random strobe masks in timer mode and random count-pin waveforms in counter mode check that only machine-cycle strobes and genuine high-to-low sample pairs advance the count. A random reload value with a long random strobe run checks the reload path against a bench model. Interleaved strobe patterns in rate mode show that machine-cycle strobes are ignored there and that exactly one baud pulse comes out per 16 wraps.

// File: rtl/tc16.sv
module tc16 #(
  parameter int BAUD_DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mc_tick,
  input  logic       st_tick,
  input  logic       cnt_pin,
  input  logic       trg_pin,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       ovf_flag,
  output logic       ext_flag,
  output logic       baud_tick,
  output logic       clk_out
);
  localparam int PW = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;
  localparam logic [2:0] A_CTRL = 3'd0, A_MODE = 3'd1, A_CLO = 3'd2,
                         A_CHI = 3'd3, A_RLO = 3'd4, A_RHI = 3'd5;

  logic run, cnt_sel, ext_en, rx_sel, tx_sel, cap_sel, dn_en, out_en;
  logic [15:0] cnt, rld, cnt_nx, rld_nx;
  logic cnt_smp, trg_smp;
  logic [PW-1:0] pre;

  wire cnt_fall   = mc_tick & cnt_smp & ~cnt_pin;
  wire trg_fall   = mc_tick & trg_smp & ~trg_pin;
  wire baud_mode  = rx_sel | tx_sel;
  wire clko_mode  = out_en & ~cnt_sel;
  wire fast       = baud_mode | clko_mode;
  wire cap_mode   = ~fast & cap_sel;
  wire ud_mode    = ~fast & ~cap_sel & dn_en;
  wire up_rl      = ~fast & ~cap_sel & ~dn_en;
  wire going_down = ud_mode & ~trg_pin;
  wire step       = run & (cnt_sel ? cnt_fall : (fast ? st_tick : mc_tick));
  wire roll       = step & ~going_down & (cnt == 16'hFFFF);
  wire under      = step & going_down & (cnt == rld);
  wire edge_hit   = ext_en & trg_fall & ~ud_mode;
  wire edge_rl    = edge_hit & up_rl;
  wire edge_cap   = edge_hit & cap_mode;
  wire wr_ctrl    = bus_wr & (bus_addr == A_CTRL);
  wire ovf_set    = (roll & ~fast) | under;
  wire ext_tgl    = ud_mode & (roll | under);

  always_comb begin
    cnt_nx = cnt;
    rld_nx = rld;
    if (edge_rl)       cnt_nx = rld;
    else if (under)    cnt_nx = 16'hFFFF;
    else if (roll)     cnt_nx = cap_mode ? 16'h0000 : rld;
    else if (step)     cnt_nx = going_down ? cnt - 16'd1 : cnt + 16'd1;
    if (edge_cap)      rld_nx = cnt;
    if (bus_wr) begin
      case (bus_addr)
        A_CLO:   cnt_nx[7:0]  = bus_wdata;
        A_CHI:   cnt_nx[15:8] = bus_wdata;
        A_RLO:   rld_nx[7:0]  = bus_wdata;
        A_RHI:   rld_nx[15:8] = bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {run, cnt_sel, ext_en, rx_sel, tx_sel, cap_sel, dn_en, out_en} <= '0;
      cnt <= '0;
      rld <= '0;
      cnt_smp <= 1'b0;
      trg_smp <= 1'b0;
      ovf_flag <= 1'b0;
      ext_flag <= 1'b0;
      pre <= '0;
      baud_tick <= 1'b0;
      clk_out <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      rld <= rld_nx;
      if (mc_tick) begin
        cnt_smp <= cnt_pin;
        trg_smp <= trg_pin;
      end
      if (wr_ctrl) begin
        run     <= bus_wdata[0];
        cnt_sel <= bus_wdata[1];
        ext_en  <= bus_wdata[2];
        rx_sel  <= bus_wdata[3];
        tx_sel  <= bus_wdata[4];
        cap_sel <= bus_wdata[5];
      end
      if (bus_wr && bus_addr == A_MODE) begin
        dn_en  <= bus_wdata[0];
        out_en <= bus_wdata[1];
      end
      ovf_flag <= ovf_set | (ovf_flag & ~(wr_ctrl & ~bus_wdata[6]));
      ext_flag <= ext_tgl ? ~ext_flag
                          : (edge_hit | (ext_flag & ~(wr_ctrl & ~bus_wdata[7])));
      baud_tick <= 1'b0;
      if (!baud_mode) pre <= '0;
      else if (roll) begin
        if (pre == PW'(BAUD_DIV - 1)) begin
          pre <= '0;
          baud_tick <= 1'b1;
        end else pre <= pre + 1'b1;
      end
      if (clko_mode && roll) clk_out <= ~clk_out;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {ext_flag, ovf_flag, cap_sel, tx_sel, rx_sel, ext_en, cnt_sel, run};
      A_MODE:  bus_rdata = {6'b0, out_en, dn_en};
      A_CLO:   bus_rdata = cnt[7:0];
      A_CHI:   bus_rdata = cnt[15:8];
      A_RLO:   bus_rdata = rld[7:0];
      A_RHI:   bus_rdata = rld[15:8];
      default: bus_rdata = 8'h00;
    endcase
  end

  assert_hold_when_stopped_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !bus_wr && !ext_en) |=> $stable(cnt));
  assert_no_flag_in_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> !$past(fast));
  assert_clkout_only_in_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_out) |-> $past(clko_mode));
  assert_baud_only_in_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> $past(baud_mode));
  assert_capture_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_cap && !bus_wr) |=> rld == $past(cnt));
  assert_underflow_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (under && !bus_wr) |=> cnt == 16'hFFFF);
  assert_ud_ignores_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ud_mode && !run && !bus_wr) |=> ($stable(cnt) && $stable(ext_flag)));
endmodule

// File: tb/tc16_tb.sv
module tc16_tb;
  logic clk = 0, rst_n = 0;
  logic mc_tick = 0, st_tick = 0, cnt_pin = 0, trg_pin = 1;
  logic bus_wr = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic ovf_flag, ext_flag, baud_tick, clk_out;
  int ntot = 0, nfail = 0;
  bit done = 0;

  localparam logic [7:0] RUN = 8'h01, CSEL = 8'h02, EXEN = 8'h04, RX = 8'h08,
                         CAP = 8'h20, KEEP = 8'hC0;

  tc16 u_dut (.clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .st_tick(st_tick),
    .cnt_pin(cnt_pin), .trg_pin(trg_pin), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_flag(ovf_flag),
    .ext_flag(ext_flag), .baud_tick(baud_tick), .clk_out(clk_out));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    ntot++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic mc, input logic st);
    mc_tick = mc; st_tick = st;
    @(posedge clk); #1;
    mc_tick = 0; st_tick = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic mc = 0);
    bus_wr = 1; bus_addr = a; bus_wdata = d; mc_tick = mc;
    @(posedge clk); #1;
    bus_wr = 0; mc_tick = 0;
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    bus_addr = lo; #1; v[7:0] = bus_rdata;
    bus_addr = lo + 3'd1; #1; v[15:8] = bus_rdata;
  endtask

  task automatic set16(input logic [2:0] lo, input logic [15:0] v);
    wr(lo, v[7:0]);
    wr(lo + 3'd1, v[15:8]);
  endtask

  function automatic logic [15:0] up_reload(input logic [15:0] c, input logic [15:0] r);
    return (c == 16'hFFFF) ? r : c + 16'd1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      ntot++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, e, r;
    logic [7:0] b;
    int n;
    bit prev, oe;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      bus_addr = 3'(a); #1;
      chk("R1 reg reset", bus_rdata, 8'h00);
    end
    chk("R1 outputs reset", {ovf_flag, ext_flag, clk_out, baud_tick}, 4'b0);

    // R2 timer operation, random strobes
    wr(0, RUN | KEEP);
    e = 0;
    for (int i = 0; i < 60; i++) begin
      logic m, s;
      m = 1'($urandom); s = 1'($urandom);
      cyc(m, s);
      if (m) e++;
    end
    rd16(2, v); chk("R2 timer count", v, e);

    // R3 counter operation, random pin
    wr(0, KEEP); set16(2, 0); wr(0, RUN | CSEL | KEEP);
    prev = 0; e = 0;
    for (int i = 0; i < 120; i++) begin
      logic m;
      m = 1'($urandom);
      cnt_pin = 1'($urandom);
      cyc(m, 0);
      if (m) begin
        if (prev && !cnt_pin) e++;
        prev = cnt_pin;
      end
    end
    rd16(2, v); chk("R3 pin count", v, e);

    // R12 stopped counter, sampler keeps tracking
    wr(0, CSEL | KEEP);
    rd16(2, r);
    cnt_pin = 1; cyc(1, 0); cnt_pin = 0; cyc(1, 0);
    rd16(2, v); chk("R12 hold while stopped", v, r);
    wr(0, RUN | CSEL | KEEP);
    repeat (3) cyc(1, 0);
    rd16(2, v); chk("R12 no stale edge", v, r);

    // R4 capture mode
    wr(0, 8'h00); set16(2, 16'hFFFE); wr(0, RUN | CAP | EXEN | KEEP);
    cyc(1, 0); cyc(1, 0);
    rd16(2, v); chk("R4 wrap to zero", v, 16'h0000);
    chk("R4 wrap flag", ovf_flag, 1);
    repeat (5) cyc(1, 0);
    trg_pin = 0; cyc(1, 0);
    rd16(4, v); chk("R4 captured value", v, 16'd5);
    rd16(2, v); chk("R4 count after capture", v, 16'd6);
    chk("R4 ext flag", ext_flag, 1);
    trg_pin = 1; cyc(1, 0);

    // R5 auto-reload up
    wr(0, 8'h00); set16(4, 16'hFFF0); set16(2, 16'hFFFE);
    wr(0, RUN | EXEN | KEEP);
    cyc(1, 0); cyc(1, 0);
    rd16(2, v); chk("R5 reload on wrap", v, 16'hFFF0);
    chk("R5 wrap flag", ovf_flag, 1);
    repeat (3) cyc(1, 0);
    trg_pin = 0; cyc(1, 0);
    rd16(2, v); chk("R5 edge reload", v, 16'hFFF0);
    chk("R5 ext flag", ext_flag, 1);
    trg_pin = 1; cyc(1, 0);
    wr(0, 8'h00);
    r = {8'hFF, 8'($urandom)}; e = {8'hFF, 8'($urandom)};
    set16(4, r); set16(2, e); wr(0, RUN | KEEP);
    oe = 0;
    for (int i = 0; i < 400; i++) begin
      logic m;
      m = 1'($urandom);
      cyc(m, 0);
      if (m) begin
        if (e == 16'hFFFF) oe = 1;
        e = up_reload(e, r);
      end
    end
    rd16(2, v); chk("R5 random reload run", v, e);
    chk("R5 random wrap flag", ovf_flag, oe);

    // R6 up/down
    wr(0, 8'h00); wr(1, 8'h01); set16(4, 16'h0010); set16(2, 16'h0012);
    trg_pin = 0; wr(0, RUN | KEEP);
    cyc(1, 0); cyc(1, 0);
    rd16(2, v); chk("R6 down count", v, 16'h0010);
    chk("R6 no flag before underflow", ovf_flag, 0);
    cyc(1, 0);
    rd16(2, v); chk("R6 underflow loads FFFF", v, 16'hFFFF);
    chk("R6 flags after underflow", {ovf_flag, ext_flag}, 2'b11);
    trg_pin = 1; cyc(1, 0);
    rd16(2, v); chk("R6 up wrap reload", v, 16'h0010);
    chk("R6 ext toggled back", ext_flag, 0);

    // R7 up/down ignores trigger edges
    wr(0, EXEN | KEEP);
    trg_pin = 0; cyc(1, 0);
    rd16(2, v); chk("R7 no edge reload", v, 16'h0010);
    chk("R7 ext unchanged", ext_flag, 0);
    trg_pin = 1; cyc(1, 0);

    // R8 rate mode
    wr(0, 8'h00); wr(1, 8'h00); set16(4, 16'hFFFE); set16(2, 16'hFFFE);
    wr(0, RX | RUN | KEEP);
    n = 0;
    for (int i = 0; i < 128; i++) begin
      cyc(i[0], !i[0]);
      if (baud_tick) n++;
    end
    chk("R8 baud pulses", n, 2);
    rd16(2, v); chk("R8 count on state ticks", v, 16'hFFFE);
    chk("R8 no wrap flag", ovf_flag, 0);

    // R9 rate mode edge
    set16(4, 16'hFFF0);
    wr(0, RX | RUN | EXEN | KEEP);
    trg_pin = 0; cyc(1, 0);
    rd16(2, v); chk("R9 no reload on edge", v, 16'hFFFE);
    chk("R9 ext set", ext_flag, 1);
    trg_pin = 1; cyc(1, 0);

    // R10 clock-out
    wr(0, 8'h00); wr(1, 8'h02); set16(4, 16'hFFFD); set16(2, 16'hFFFD);
    wr(0, RUN | KEEP);
    n = 0; b[0] = clk_out;
    for (int i = 0; i < 30; i++) begin
      cyc(0, 1);
      if (clk_out !== b[0]) n++;
      b[0] = clk_out;
    end
    chk("R10 clock toggles", n, 10);
    chk("R10 no wrap flag", ovf_flag, 0);

    // R11 flag write priority
    wr(0, 8'h00); wr(1, 8'h00); set16(4, 0); set16(2, 16'hFFFF);
    wr(0, RUN);
    wr(0, RUN, 1);
    chk("R11 hardware set wins", ovf_flag, 1);
    wr(0, RUN | KEEP);
    chk("R11 write one keeps", ovf_flag, 1);
    wr(0, RUN);
    chk("R11 write zero clears", ovf_flag, 0);

    done = 1;
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule